// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the target-side serial engine of a NOR flash that speaks SPI in mode 0. It watches chip select, the serial clock, the serial input and a pause input. It oversamples all four with the chip's system clock, shifts in an 8-bit instruction and works out which command it is. Depending on the command, it then collects a 24-bit address, streams bytes out of a small internal byte array, returns the identification bytes or repeats a status byte supplied from outside. Commands that program, erase or change protection are not carried out here. Their data bytes go to a separate write-cycle controller as they arrive. The command itself is handed over as a single commit pulse when chip select rises on a byte boundary.

The write-cycle controller fills the byte array through a simple write port. It reports whether a self-timed cycle is running, and it supplies the status byte. While a cycle is running, the front end accepts only the status-read command. An unknown opcode makes the block fall silent for the rest of the selection. The pause input freezes a transfer mid-byte and lets it resume later.

Top module: `spi_flash_fe`

## Requirements
- R1: After reset, so_oe, cmd_valid and data_valid are all low.
- R2: While cs_n is high, activity on sck and si has no effect: so_oe stays low and no cmd_valid or data_valid pulse occurs.
- R3: Each selection starts on a falling cs_n. The first 8 si bits, sampled on rising sck and taken MSB first, form the opcode. Opcode bit 3 is ignored. Recognised patterns: 0000x110 write-enable, 0000x100 write-disable, 0000x101 status read, 0000x001 status write, 0000x011 array read, 0000x010 page program, 0101x010 sector erase, 0110x010 chip erase, 0001x101 identification read.
- R4: Array read takes a 24-bit address, MSB first, of which only the low AW bits are used. Data then leaves MSB first. so changes only after a falling sck edge, and the first data bit appears after the falling edge that follows the last address bit.
- R5: During an array read, the address increments after every byte and wraps from MEM_BYTES-1 to 0.
- R6: Identification read returns MFR_ID (default 0x1F) and then DEV_ID (default 0x64). After those two bytes, so_oe stays low.
- R7: Status read returns stat_in, latched again at the start of every byte, for as long as the clock continues.
- R8: An unrecognised opcode keeps so_oe low and ignores all further input, with no pulses, until the next falling cs_n. The next selection then works normally.
- R9: hold_n taken low while sck is low pauses the transfer. While paused, so_oe is low and sck and si are ignored. hold_n taken high while sck is low resumes the transfer with no bit lost.
- R10: A write-type command commits with a one-cycle cmd_valid after cs_n rises with no partial byte pending. cmd_op codes: write-enable 1, write-disable 2, status write 4, page program 6, sector erase 7, chip erase 8. Sector erase commits after its address. Page program needs at least one data byte and puts its start address on cmd_addr.
- R11: Each complete data byte of a page program, and the single data byte of a status write, produces a one-cycle data_valid with the byte on data_byte.
- R12: If wr_busy is high when the opcode completes, every opcode except status read is ignored, as in R8.
- R13: A one-cycle mem_we writes mem_wdata to array location mem_waddr. Later array reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| wr_busy | input | 1 | Write-cycle controller is running a self-timed cycle |
| stat_in | input | 8 | Status byte returned by status read |
| cmd_valid | output | 1 | One-cycle commit of a write-type command |
| cmd_op | output | 4 | Code of the committed command |
| cmd_addr | output | AW (8) | Start address of page program or sector erase |
| data_valid | output | 1 | One-cycle strobe for a received data byte |
| data_byte | output | 8 | Received data byte |
| mem_we | input | 1 | Array write strobe from the write-cycle controller |
| mem_waddr | input | AW (8) | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The hardest state to reach from the ports is a pause in the middle of an output byte. The bench has to stop the clock at a low phase after exactly four bits of the second read byte have gone out. It then lowers hold_n, toggles sck with si high while paused, and raises hold_n again while sck is low. The reassembled byte must still match the next array location. Wrap-around and the refusal of a truncated page program are reached in the same way: a read starts two bytes below the top of the array, and chip select is raised after half a data byte.

// File: rtl/spi_fe_pkg.sv
// Shared types for the SPI flash command front end.
// Assumes: nothing beyond 1800-2017 enums.
package spi_fe_pkg;

    // Command codes; the values are visible on cmd_op.
    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_WREN   = 4'd1,
        OP_WRDI   = 4'd2,
        OP_RDSR   = 4'd3,
        OP_WRSR   = 4'd4,
        OP_READ   = 4'd5,
        OP_PROG   = 4'd6,
        OP_SERASE = 4'd7,
        OP_CERASE = 4'd8,
        OP_RDID   = 4'd9
    } op_e;

    // Phases of one chip-select window.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WIN,
        ST_OUT,
        ST_DONE,
        ST_DEAD
    } st_e;

endpackage

// File: rtl/spi_fe_sync.sv
// Brings cs_n, sck, si and hold_n into the clk domain through SYNC_STAGES
// flops, detects edges of sck and cs_n, and tracks the pause state.
// Assumes: sck runs well below clk/4, so every sck phase spans several clks.
module spi_fe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic si_q,
    output logic cs_q,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic hold_act
);
    // bit order in each stage: [3] hold_n, [2] cs_n, [1] si, [0] sck
    localparam logic [3:0] IDLE_VEC = 4'b1100;

    logic [SYNC_STAGES-1:0][3:0] stg;
    logic [3:0] cur;
    logic       sck_p, cs_p;

    // Synchronizer pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stg[k] <= IDLE_VEC;
        end else begin
            stg[0] <= {hold_n, cs_n, si, sck};
            for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign cur = stg[SYNC_STAGES-1];

    // Previous sample of sck and cs_n, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            cs_p  <= 1'b1;
        end else begin
            sck_p <= cur[0];
            cs_p  <= cur[2];
        end
    end

    // Pause state: changes only while sck is low; cleared on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n)       hold_act <= 1'b0;
        else if (cur[2])  hold_act <= 1'b0;
        else if (!cur[0]) hold_act <= !cur[3];
    end

    assign si_q     = cur[1];
    assign cs_q     = cur[2];
    assign sck_rise = cur[0] & ~sck_p & ~hold_act & ~cur[2];
    assign sck_fall = ~cur[0] & sck_p & ~hold_act & ~cur[2];
    assign cs_fall  = ~cur[2] & cs_p;
    assign cs_rise  = cur[2] & ~cs_p;

endmodule

// File: rtl/spi_fe_decode.sv
// Maps a received opcode byte to a command code; bit 3 is ignored.
// Assumes: purely combinational, no state.
module spi_fe_decode
    import spi_fe_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op
);
    // Pattern match with bit 3 wildcarded.
    always_comb begin
        casez (code)
            8'b0000_?110: op = OP_WREN;
            8'b0000_?100: op = OP_WRDI;
            8'b0000_?101: op = OP_RDSR;
            8'b0000_?001: op = OP_WRSR;
            8'b0000_?011: op = OP_READ;
            8'b0000_?010: op = OP_PROG;
            8'b0101_?010: op = OP_SERASE;
            8'b0110_?010: op = OP_CERASE;
            8'b0001_?101: op = OP_RDID;
            default:      op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/spi_fe_array.sv
// Byte array with one synchronous write port and one asynchronous read port.
// Assumes: contents are not reset; the write-cycle controller fills them.
module spi_fe_array #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_flash_fe.sv
// SPI mode-0 command front end: opcode, address and data phases, read
// streaming, identification, status read, pause, and commit of write-type
// commands to an external write-cycle controller.
// Assumes: MEM_BYTES is a power of two, at least 4 and at most 2**24.
module spi_flash_fe
    import spi_fe_pkg::*;
#(
    parameter int         MEM_BYTES   = 256,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_ID      = 8'h1F,
    parameter logic [7:0] DEV_ID      = 8'h64,
    parameter int         AW          = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          hold_n,
    output logic          so,
    output logic          so_oe,
    input  logic          wr_busy,
    input  logic [7:0]    stat_in,
    output logic          cmd_valid,
    output logic [3:0]    cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic          data_valid,
    output logic [7:0]    data_byte,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [7:0]    mem_wdata
);
    logic          si_q, cs_q, sck_rise, sck_fall, cs_fall, cs_rise, hold_act;
    st_e           st;
    op_e           op_r, dec_op;
    logic [2:0]    bitcnt;
    logic [1:0]    abyte;
    logic [6:0]    sh;
    logic [7:0]    sh_n;
    logic [AW-1:0] addr_acc, addr_full, rd_addr;
    logic [7:0]    tx, nxt, mem_rdata;
    logic [2:0]    out_cnt;
    logic [1:0]    id_idx;
    logic          live, got, so_r, commit;

    spi_fe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .si_q(si_q), .cs_q(cs_q), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .hold_act(hold_act)
    );

    spi_fe_decode u_dec (.code(sh_n), .op(dec_op));

    spi_fe_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(mem_rdata)
    );

    assign sh_n      = {sh, si_q};
    assign addr_full = {addr_acc[AW-2:0], si_q};

    // Byte to present next, chosen by the active output command.
    always_comb begin
        case (op_r)
            OP_READ: nxt = mem_rdata;
            OP_RDSR: nxt = stat_in;
            OP_RDID: nxt = (id_idx == 2'd0) ? MFR_ID : DEV_ID;
            default: nxt = 8'h00;
        endcase
    end

    // A write-type command is complete and ends on a byte boundary.
    always_comb begin
        commit = 1'b0;
        if (bitcnt == 3'd0) begin
            if (st == ST_DONE &&
                op_r inside {OP_WREN, OP_WRDI, OP_WRSR, OP_SERASE, OP_CERASE})
                commit = 1'b1;
            if (st == ST_WIN && op_r == OP_PROG && got)
                commit = 1'b1;
        end
    end

    // Main sequencer: per-selection phases, input shifting, output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; op_r <= OP_NONE; bitcnt <= '0; abyte <= '0;
            sh <= '0; addr_acc <= '0; rd_addr <= '0; cmd_addr <= '0;
            tx <= '0; out_cnt <= '0; id_idx <= '0; live <= 1'b0;
            got <= 1'b0; so_r <= 1'b0; cmd_valid <= 1'b0;
            data_valid <= 1'b0; data_byte <= '0;
        end else begin
            cmd_valid  <= 1'b0;
            data_valid <= 1'b0;
            if (cs_fall) begin
                st <= ST_OPC; bitcnt <= '0; abyte <= '0; got <= 1'b0;
                live <= 1'b0; id_idx <= '0; out_cnt <= '0;
            end else if (cs_rise) begin
                cmd_valid <= commit;
                st        <= ST_IDLE;
                live      <= 1'b0;
            end else if (sck_rise && st != ST_IDLE) begin
                bitcnt <= bitcnt + 3'd1;
                sh     <= sh_n[6:0];
                case (st)
                    ST_OPC: if (bitcnt == 3'd7) begin
                        op_r <= dec_op;
                        if (wr_busy && dec_op != OP_RDSR) st <= ST_DEAD;
                        else begin
                            case (dec_op)
                                OP_RDSR, OP_RDID:         st <= ST_OUT;
                                OP_READ, OP_PROG, OP_SERASE: st <= ST_ADDR;
                                OP_WRSR:                  st <= ST_WIN;
                                OP_NONE:                  st <= ST_DEAD;
                                default:                  st <= ST_DONE;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        addr_acc <= addr_full;
                        if (bitcnt == 3'd7) begin
                            abyte <= abyte + 2'd1;
                            if (abyte == 2'd2) begin
                                cmd_addr <= addr_full;
                                rd_addr  <= addr_full;
                                case (op_r)
                                    OP_READ: st <= ST_OUT;
                                    OP_PROG: st <= ST_WIN;
                                    default: st <= ST_DONE;
                                endcase
                            end
                        end
                    end
                    ST_WIN: if (bitcnt == 3'd7) begin
                        data_valid <= 1'b1;
                        data_byte  <= sh_n;
                        got        <= 1'b1;
                        if (op_r == OP_WRSR) st <= ST_DONE;
                    end
                    default: ;
                endcase
            end else if (sck_fall && st == ST_OUT) begin
                if (out_cnt == 3'd0) begin
                    if (op_r == OP_RDID && id_idx == 2'd2) begin
                        live <= 1'b0;
                        st   <= ST_DONE;
                    end else begin
                        so_r    <= nxt[7];
                        tx      <= {nxt[6:0], 1'b0};
                        out_cnt <= 3'd7;
                        live    <= 1'b1;
                        if (op_r == OP_RDID) id_idx  <= id_idx + 2'd1;
                        if (op_r == OP_READ) rd_addr <= rd_addr + 1'b1;
                    end
                end else begin
                    so_r    <= tx[7];
                    tx      <= {tx[6:0], 1'b0};
                    out_cnt <= out_cnt - 3'd1;
                end
            end
        end
    end

    assign so_oe  = live & ~hold_act & ~cs_q;
    assign so     = so_oe ? so_r : 1'b0;
    assign cmd_op = op_r;

endmodule

// File: rtl/spi_fe_chk.sv
// Protocol checker for spi_flash_fe, attached to every instance by bind.
// Assumes: clocked on clk with the same synchronous reset.
module spi_fe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       data_valid,
    input logic [3:0] cmd_op,
    input logic       so,
    input logic       so_oe,
    input logic       sck_fall,
    input logic       cs_rise,
    input logic       hold_act,
    input logic [2:0] bitcnt
);
    // R10
    commit_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(cs_rise));
    // R10
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R10
    commit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op inside {4'd1, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8}));
    // R11
    data_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    // R11
    data_not_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> !cmd_valid);
    // R4
    so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && so != $past(so)) |-> $past(sck_fall));
    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && $past(hold_act)) |-> ($stable(bitcnt) && !so_oe));

endmodule

bind spi_flash_fe spi_fe_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .data_valid(data_valid),
    .cmd_op(cmd_op), .so(so), .so_oe(so_oe), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .hold_act(hold_act), .bitcnt(bitcnt)
);

// File: tb/sim_spi_flash_fe.sv
module sim_spi_flash_fe;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, wr_busy = 1'b0;
    logic [7:0] stat_in = 8'h00;
    logic cmd_valid, data_valid;
    logic [3:0] cmd_op;
    logic [7:0] cmd_addr, data_byte;
    logic mem_we = 1'b0;
    logic [7:0] mem_waddr = 8'h00, mem_wdata = 8'h00;

    int checks = 0, fails = 0, cmd_cnt = 0, quiet_hits = 0;
    int last_op = 0, last_addr = 0;
    bit quiet = 1'b0, done = 1'b0;
    byte unsigned ref_mem [256];
    byte unsigned data_q [$];

    always #2 clk = ~clk;

    spi_flash_fe u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe), .wr_busy(wr_busy),
        .stat_in(stat_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .data_valid(data_valid), .data_byte(data_byte),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    // Per-clock observer: records commits, data strobes and output leaks.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                cmd_cnt++; last_op = cmd_op; last_addr = cmd_addr;
            end
            if (data_valid) data_q.push_back(data_byte);
            if (quiet && so_oe) quiet_hits++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b, output logic r, output logic oe);
        si = b;
        repeat (8) @(negedge clk);
        r = so; oe = so_oe;
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] t, output logic [7:0] r,
                         output logic [7:0] oev);
        for (int i = 7; i >= 0; i--) begin
            logic b, o;
            sbit(t[i], b, o);
            r[i] = b; oev[i] = o;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic desel();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] r, o;
        sbyte(a[23:16], r, o);
        sbyte(a[15:8], r, o);
        sbyte(a[7:0], r, o);
    endtask

    // Array read compared with the bench's mirror of the array.
    task automatic do_read(input logic [7:0] opc, input logic [23:0] a,
                           input int n, input string req);
        logic [7:0] r, o;
        sel();
        sbyte(opc, r, o);
        send_addr(a);
        for (int k = 0; k < n; k++) begin
            sbyte(8'h00, r, o);
            chk(req, r, ref_mem[(int'(a[7:0]) + k) % 256]);
            chk(req, o, 8'hFF);
        end
        desel();
    endtask

    task automatic cmd_only(input logic [7:0] opc);
        logic [7:0] r, o;
        sel(); sbyte(opc, r, o); desel();
    endtask

    initial begin
        logic [7:0] r, o;
        logic b, ob;
        int c0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 so_oe", so_oe, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 data_valid", data_valid, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R13 fill the array through the write port
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = byte'((i * 37 + 11) & 255);
            mem_we = 1'b1; mem_waddr = 8'(i); mem_wdata = ref_mem[i];
            @(negedge clk);
        end
        mem_we = 1'b0;

        // R4 R13 read with upper address bits set (ignored)
        do_read(8'h03, 24'hF80010, 4, "R4 read");
        // R5 wrap from top of array; R3 bit3 set in opcode
        do_read(8'h0B, 24'h0000FE, 4, "R5 wrap");

        // R6 identification bytes, then silence
        sel();
        sbyte(8'h1D, r, o);
        sbyte(8'h00, r, o); chk("R6 mfr", r, 8'h1F); chk("R6 mfr oe", o, 8'hFF);
        sbyte(8'h00, r, o); chk("R6 dev", r, 8'h64); chk("R6 dev oe", o, 8'hFF);
        sbyte(8'h00, r, o); chk("R6 released", o, 8'h00);
        desel();

        // R7 status byte repeats
        stat_in = 8'hA5;
        sel();
        sbyte(8'h05, r, o);
        sbyte(8'h00, r, o); chk("R7 status", r, 8'hA5);
        stat_in = 8'h3C;
        sbyte(8'h00, r, o); chk("R7 status again", r, 8'h3C);
        desel();

        // R8 invalid opcode: silence, no commit, then recovery
        c0 = cmd_cnt;
        sel();
        sbyte(8'h20, r, o);
        quiet = 1'b1;
        sbyte(8'hFF, r, o); sbyte(8'h00, r, o);
        quiet = 1'b0;
        desel();
        chk("R8 silent", quiet_hits, 0);
        chk("R8 no commit", cmd_cnt, c0);
        do_read(8'h03, 24'h000040, 1, "R8 recovery");

        // R2 deselected activity ignored
        c0 = cmd_cnt;
        quiet = 1'b1;
        for (int i = 0; i < 16; i++) begin
            si = i[0]; sck = 1'b1; repeat (6) @(negedge clk);
            sck = 1'b0; repeat (6) @(negedge clk);
        end
        quiet = 1'b0;
        chk("R2 quiet", quiet_hits, 0);
        chk("R2 no commit", cmd_cnt, c0);
        chk("R2 no data", data_q.size(), 0);

        // R10 R3 write-type commits
        cmd_only(8'h06); chk("R10 wren count", cmd_cnt, c0 + 1); chk("R10 wren op", last_op, 1);
        cmd_only(8'h0C); chk("R10 wrdi op", last_op, 2);
        cmd_only(8'h62); chk("R10 chip erase op", last_op, 8);
        sel(); sbyte(8'h5A, r, o); send_addr(24'h030045); desel();
        chk("R10 sector erase op", last_op, 7); chk("R10 sector addr", last_addr, 8'h45);

        // R11 R10 page program with three bytes
        data_q.delete();
        sel(); sbyte(8'h02, r, o); send_addr(24'h0000F0);
        sbyte(8'hAA, r, o); sbyte(8'h55, r, o); sbyte(8'h3C, r, o);
        desel();
        chk("R11 data count", data_q.size(), 3);
        if (data_q.size() == 3) begin
            chk("R11 byte0", data_q[0], 8'hAA);
            chk("R11 byte2", data_q[2], 8'h3C);
        end
        chk("R10 program op", last_op, 6); chk("R10 program addr", last_addr, 8'hF0);

        // R11 status write takes one byte
        data_q.delete();
        sel(); sbyte(8'h01, r, o); sbyte(8'h9C, r, o); desel();
        chk("R11 wrsr data", data_q.size() == 1 ? int'(data_q[0]) : -1, 8'h9C);
        chk("R10 wrsr op", last_op, 4);

        // R10 truncated program: no commit
        c0 = cmd_cnt;
        sel(); sbyte(8'h02, r, o); send_addr(24'h000010);
        for (int i = 0; i < 4; i++) sbit(1'b1, b, ob);
        desel();
        chk("R10 partial no commit", cmd_cnt, c0);

        // R12 busy: write-enable and read ignored, status read served
        wr_busy = 1'b1; stat_in = 8'h81;
        c0 = cmd_cnt;
        cmd_only(8'h06);
        chk("R12 busy no commit", cmd_cnt, c0);
        sel(); sbyte(8'h03, r, o); quiet = 1'b1;
        send_addr(24'h000000); sbyte(8'h00, r, o); quiet = 1'b0; desel();
        chk("R12 busy read silent", quiet_hits, 0);
        sel(); sbyte(8'h05, r, o); sbyte(8'h00, r, o); desel();
        chk("R12 busy status", r, 8'h81);
        wr_busy = 1'b0;

        // R9 pause in the middle of the second read byte
        sel(); sbyte(8'h03, r, o); send_addr(24'h000080);
        sbyte(8'h00, r, o); chk("R9 first byte", r, ref_mem[8'h80]);
        for (int i = 7; i >= 4; i--) begin
            sbit(1'b0, b, ob); r[i] = b;
        end
        repeat (4) @(negedge clk);
        hold_n = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 paused so_oe", so_oe, 0);
        for (int i = 0; i < 2; i++) begin
            si = 1'b1; sck = 1'b1; repeat (8) @(negedge clk);
            sck = 1'b0; repeat (8) @(negedge clk);
            chk("R9 still paused", so_oe, 0);
        end
        hold_n = 1'b1;
        repeat (8) @(negedge clk);
        for (int i = 3; i >= 0; i--) begin
            sbit(1'b0, b, ob); r[i] = b;
        end
        chk("R9 resumed byte", r, ref_mem[8'h81]);
        sbyte(8'h00, r, o); chk("R9 third byte", r, ref_mem[8'h82]);
        desel();

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule